// File: doc/BRIEF.md
# Output Divider Bank With Crosspoint

This block produces six clock outputs from two input clocks: a fast oscillator clock and a reference clock. There are two divider banks. Each bank runs from whichever of the two clocks its control byte selects. Each bank drives three taps:

- a divide-by-two tap;
- a divide-by-N tap, where N is held in the same control byte;
- a fixed extra tap, which is divide-by-three in the first bank and divide-by-four in the second.

A crosspoint gives each output a 3-bit source code. The code picks one of the six bank taps or the raw reference clock.

A register-write port sets up the banks, the crosspoint and a per-output enable byte. An output-enable pin gates all six outputs together. A disabled output is handed to its pad as high impedance, so each output comes as a data bit plus a pad drive-enable bit. When the enable bit is low, the data bit is held low.

At reset, output 1 is enabled and carries the reference clock. Outputs 2 to 6 are undriven.

Top module: `odb_clkout`

## Requirements
- R1: After reset, clk_oe_o is 6'b000001 while oe_pin is high. clk_o[0] runs at the reference frequency and clk_o[5:1] stay low.
- R2: Bit 7 of the bank-1 control byte (address 0x0C) and of the bank-2 control byte (address 0x47) selects that bank's source clock: 0 for the reference, 1 for the oscillator clock.
- R3: Bits 6:0 of each bank control byte hold N. The divide-by-N tap of that bank has a period of N source cycles.
- R4: An N value of 0 or 1 gives a divide-by-two on the divide-by-N tap.
- R5: Each bank's divide-by-two tap toggles on every source edge. Bank 1's fixed tap divides by 3 and bank 2's fixed tap divides by 4.
- R6: The source codes are:
  - 0: reference;
  - 1: bank-1 divide-by-N;
  - 2: bank-1 divide-by-two;
  - 3: divide-by-three;
  - 4: bank-2 divide-by-N;
  - 5: bank-2 divide-by-two;
  - 6: divide-by-four;
  - 7: holds the output low.
- R7: The six codes are packed MSB-first, output 1 first, over addresses 0x44 to 0x46:
  - output 1 is 0x44[7:5];
  - output 2 is 0x44[4:2];
  - output 3 is {0x44[1:0], 0x45[7]};
  - output 4 is 0x45[6:4];
  - output 5 is {0x45[0], 0x46[7:6]};
  - output 6 is 0x46[5:3].

  Bits 0x45[3:1] and 0x46[2:0] are fixed and writes to them have no effect.
- R8: The enable byte (address 0x09) enables outputs as follows:
  - bits 3:0 enable outputs 1 to 4;
  - bit 5 enables output 5;
  - bit 6 enables output 6.

  Bits 7 and 4 are ignored.
- R9: While oe_pin is low, every clk_oe_o bit is 0 and no output toggles.
- R10: An output whose clk_oe_o bit is 0 holds clk_o low, so its pad is in high impedance.
- R11: A write to any other address changes no output, enable or frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on reg_clk |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register data |
| vco_clk | input | 1 | Oscillator clock |
| ref_clk | input | 1 | Reference clock |
| oe_pin | input | 1 | Global output enable, active high |
| clk_o | output | 6 | Output clocks (pad data) |
| clk_oe_o | output | 6 | Pad drive enables; 0 means high impedance |

## Verification
The bench builds the block with its default parameters: a 7-bit N, a fixed divide-by-three in bank 1 and a fixed divide-by-four in bank 2. These defaults exercise both generate variants of the fixed tap, the counter form and the power-of-two form. They also allow N to span from the sub-two values through to 127. Frequencies are checked by counting output edges over a fixed window against reference and oscillator clocks of 40 ns and 10 ns. This makes each source code and each bank source choice visible as a distinct edge count. A packing test uses six different codes in one pass, with the fixed bits written to zero, to expose any misplaced code bit.

// File: rtl/odb_pkg.sv
`timescale 1ns/1ps
package odb_pkg;
   localparam int N_OUT    = 6;
   localparam int SEL_W    = 3;
   localparam int SEL_BITS = N_OUT * SEL_W;

   typedef enum logic [SEL_W-1:0] {
      TAP_REF   = 3'd0,
      TAP_B1_N  = 3'd1,
      TAP_B1_H  = 3'd2,
      TAP_B1_FX = 3'd3,
      TAP_B2_N  = 3'd4,
      TAP_B2_H  = 3'd5,
      TAP_B2_FX = 3'd6,
      TAP_OFF   = 3'd7
   } tap_sel_e;
endpackage

// File: rtl/odb_div.sv
`timescale 1ns/1ps
module odb_div #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] div,
   output logic         q
);
   logic [W-1:0] n_eff;
   logic [W-1:0] half;
   logic [W-1:0] cnt;

   if (W < 2) begin : g_bad_w
      $error("odb_div: W must be at least 2");
   end

   assign n_eff = (div < W'(2)) ? W'(2) : div;
   assign half  = n_eff >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         q   <= 1'b1;
      end else if (cnt >= n_eff - W'(1)) begin
         cnt <= '0;
         q   <= 1'b1;
      end else begin
         cnt <= cnt + W'(1);
         q   <= (cnt + W'(1)) < half;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(div) |=> (cnt < n_eff)) else $error("count beyond divisor"); // R3
endmodule

// File: rtl/odb_bank.sv
`timescale 1ns/1ps
module odb_bank #(
   parameter int DIVN_W  = 7,
   parameter int FIX_DIV = 3
) (
   input  logic              vco_clk,
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              use_vco,
   input  logic [DIVN_W-1:0] divn,
   output logic              tap_n,
   output logic              tap_half,
   output logic              tap_fix
);
   localparam bit FIX_POW2 = ((FIX_DIV & (FIX_DIV - 1)) == 0);
   localparam int FIX_W    = (FIX_DIV < 4) ? 2 : $clog2(FIX_DIV + 1);

   logic bclk;

   if (FIX_DIV < 2) begin : g_bad_fix
      $error("odb_bank: FIX_DIV must be at least 2");
   end

   assign bclk = use_vco ? vco_clk : ref_clk;

   odb_div #(.W(DIVN_W)) u_divn (
      .clk(bclk), .rst_n(rst_n), .div(divn), .q(tap_n));

   odb_div #(.W(2)) u_half (
      .clk(bclk), .rst_n(rst_n), .div(2'd2), .q(tap_half));

   if (FIX_POW2) begin : g_fix_pow2
      localparam int PW = $clog2(FIX_DIV);
      logic [PW-1:0] pcnt;
      always_ff @(posedge bclk or negedge rst_n) begin
         if (!rst_n) pcnt <= '0;
         else        pcnt <= pcnt + PW'(1);
      end
      assign tap_fix = pcnt[PW-1];
   end else begin : g_fix_cnt
      odb_div #(.W(FIX_W)) u_fix (
         .clk(bclk), .rst_n(rst_n), .div(FIX_W'(FIX_DIV)), .q(tap_fix));
   end

   AST_HALF_TOGGLE: assert property (@(posedge bclk) disable iff (!rst_n)
      1'b1 |=> (tap_half != $past(tap_half))) else $error("half tap stuck"); // R5
endmodule

// File: rtl/odb_regs.sv
`timescale 1ns/1ps
module odb_regs
   import odb_pkg::*;
#(
   parameter int         DIVN_W = 7,
   parameter logic [7:0] A_EN   = 8'h09,
   parameter logic [7:0] A_B1   = 8'h0C,
   parameter logic [7:0] A_B2   = 8'h47,
   parameter logic [7:0] A_SEL  = 8'h44
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [7:0]          wr_addr,
   input  logic [7:0]          wr_data,
   output logic                b1_vco,
   output logic [DIVN_W-1:0]   b1_divn,
   output logic                b2_vco,
   output logic [DIVN_W-1:0]   b2_divn,
   output logic [SEL_BITS-1:0] sel_flat,
   output logic [N_OUT-1:0]    out_en
);
   localparam logic [7:0] A_SEL_MID = A_SEL + 8'd1;
   localparam logic [7:0] A_SEL_LO  = A_SEL + 8'd2;

   logic hit;
   assign hit = wr_en && ((wr_addr == A_EN) || (wr_addr == A_B1) || (wr_addr == A_B2) ||
                          (wr_addr == A_SEL) || (wr_addr == A_SEL_MID) || (wr_addr == A_SEL_LO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b1_vco   <= 1'b0;
         b1_divn  <= '0;
         b2_vco   <= 1'b0;
         b2_divn  <= '0;
         sel_flat <= '0;
         out_en   <= N_OUT'(1);
      end else if (wr_en) begin
         unique case (wr_addr)
            A_EN:      out_en <= {wr_data[6], wr_data[5], wr_data[3:0]};
            A_B1:      begin b1_vco <= wr_data[7]; b1_divn <= wr_data[DIVN_W-1:0]; end
            A_B2:      begin b2_vco <= wr_data[7]; b2_divn <= wr_data[DIVN_W-1:0]; end
            A_SEL:     sel_flat[17:10] <= wr_data;
            A_SEL_MID: begin sel_flat[9:6] <= wr_data[7:4]; sel_flat[5] <= wr_data[0]; end
            A_SEL_LO:  sel_flat[4:0] <= wr_data[7:3];
            default:   ;
         endcase
      end
   end

   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_EN) |=>
      (out_en == {$past(wr_data[6]), $past(wr_data[5]), $past(wr_data[3:0])}))
      else $error("enable byte mapping"); // R8
   AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> ($stable(out_en) && $stable(sel_flat) && $stable(b1_divn) && $stable(b2_divn)
                && $stable(b1_vco) && $stable(b2_vco)))
      else $error("state changed without a hit"); // R11
endmodule

// File: rtl/odb_clkout.sv
`timescale 1ns/1ps
module odb_clkout
   import odb_pkg::*;
#(
   parameter int         DIVN_W  = 7,
   parameter int         B1_FIX  = 3,
   parameter int         B2_FIX  = 4,
   parameter logic [7:0] A_EN    = 8'h09,
   parameter logic [7:0] A_B1    = 8'h0C,
   parameter logic [7:0] A_B2    = 8'h47,
   parameter logic [7:0] A_SEL   = 8'h44
) (
   input  logic             reg_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             vco_clk,
   input  logic             ref_clk,
   input  logic             oe_pin,
   output logic [N_OUT-1:0] clk_o,
   output logic [N_OUT-1:0] clk_oe_o
);
   if (DIVN_W < 2 || DIVN_W > 7) begin : g_bad_divn
      $error("odb_clkout: DIVN_W must lie in 2..7 (bit 7 is the source select)");
   end

   logic                b1_vco, b2_vco;
   logic [DIVN_W-1:0]   b1_divn, b2_divn;
   logic [SEL_BITS-1:0] sel_flat;
   logic [N_OUT-1:0]    out_en;
   logic                b1_n, b1_h, b1_fx, b2_n, b2_h, b2_fx;

   odb_regs #(.DIVN_W(DIVN_W), .A_EN(A_EN), .A_B1(A_B1), .A_B2(A_B2), .A_SEL(A_SEL)) u_regs (
      .clk(reg_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .b1_vco(b1_vco), .b1_divn(b1_divn), .b2_vco(b2_vco), .b2_divn(b2_divn),
      .sel_flat(sel_flat), .out_en(out_en));

   odb_bank #(.DIVN_W(DIVN_W), .FIX_DIV(B1_FIX)) u_bank1 (
      .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .use_vco(b1_vco), .divn(b1_divn),
      .tap_n(b1_n), .tap_half(b1_h), .tap_fix(b1_fx));

   odb_bank #(.DIVN_W(DIVN_W), .FIX_DIV(B2_FIX)) u_bank2 (
      .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .use_vco(b2_vco), .divn(b2_divn),
      .tap_n(b2_n), .tap_half(b2_h), .tap_fix(b2_fx));

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      tap_sel_e sel;
      logic     mux;

      assign sel = tap_sel_e'(sel_flat[SEL_BITS-1-SEL_W*i -: SEL_W]);

      always_comb begin
         unique case (sel)
            TAP_REF:   mux = ref_clk;
            TAP_B1_N:  mux = b1_n;
            TAP_B1_H:  mux = b1_h;
            TAP_B1_FX: mux = b1_fx;
            TAP_B2_N:  mux = b2_n;
            TAP_B2_H:  mux = b2_h;
            TAP_B2_FX: mux = b2_fx;
            default:   mux = 1'b0;
         endcase
      end

      assign clk_oe_o[i] = oe_pin & out_en[i];
      assign clk_o[i]    = clk_oe_o[i] & mux;

      AST_RSVD_LOW: assert property (@(posedge reg_clk) disable iff (!rst_n)
         (sel == TAP_OFF) |-> !clk_o[i]) else $error("reserved code drives"); // R6
      AST_OFF_LOW: assert property (@(posedge reg_clk) disable iff (!rst_n)
         !clk_oe_o[i] |-> !clk_o[i]) else $error("undriven pad toggles"); // R10
   end

   AST_PIN_GATE: assert property (@(posedge reg_clk) disable iff (!rst_n)
      !oe_pin |-> (clk_oe_o == '0)) else $error("pin low but pad driven"); // R9
endmodule

// File: tb/tb_odb_clkout.sv
`timescale 1ns/1ps
module tb_odb_clkout;
   localparam int  REF_P = 40;
   localparam int  VCO_P = 10;
   localparam int  WIN   = 4800;
   localparam int  NV    = 12;
   // entry: {out_idx[2:0], code[2:0], s1, n1[6:0], s2, n2[6:0]}
   localparam logic [21:0] VEC [NV] = '{
      {3'd0, 3'd0, 1'b0, 7'd5,   1'b0, 7'd4},
      {3'd1, 3'd1, 1'b1, 7'd6,   1'b0, 7'd4},
      {3'd2, 3'd2, 1'b0, 7'd6,   1'b0, 7'd4},
      {3'd3, 3'd3, 1'b1, 7'd6,   1'b0, 7'd4},
      {3'd4, 3'd4, 1'b0, 7'd6,   1'b0, 7'd3},
      {3'd5, 3'd5, 1'b0, 7'd6,   1'b1, 7'd3},
      {3'd0, 3'd6, 1'b0, 7'd6,   1'b1, 7'd3},
      {3'd1, 3'd1, 1'b0, 7'd0,   1'b1, 7'd3},
      {3'd2, 3'd4, 1'b0, 7'd0,   1'b1, 7'd1},
      {3'd3, 3'd7, 1'b1, 7'd9,   1'b1, 7'd9},
      {3'd5, 3'd1, 1'b1, 7'd127, 1'b0, 7'd9},
      {3'd4, 3'd6, 1'b1, 7'd127, 1'b0, 7'd9}
   };

   logic       reg_clk = 0, vco_clk = 0, ref_clk = 0;
   logic       rst_n = 0, wr_en = 0, oe_pin = 1;
   logic [7:0] wr_addr = 0, wr_data = 0;
   logic [5:0] clk_o, clk_oe_o;
   int         ecnt [6];
   int         total = 0, failed = 0;

   always #10 reg_clk = ~reg_clk;
   always #(REF_P/2) ref_clk = ~ref_clk;
   always #(VCO_P/2) vco_clk = ~vco_clk;

   odb_clkout dut (.reg_clk(reg_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .vco_clk(vco_clk), .ref_clk(ref_clk), .oe_pin(oe_pin),
      .clk_o(clk_o), .clk_oe_o(clk_oe_o));

   for (genvar k = 0; k < 6; k++) begin : g_mon
      always @(posedge clk_o[k]) ecnt[k] = ecnt[k] + 1;
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge reg_clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge reg_clk); wr_en = 0;
   endtask

   task automatic put_codes(input logic [17:0] f);
      wr(8'h44, f[17:10]);
      wr(8'h45, {f[9:6], 3'b111, f[5]});
      wr(8'h46, {f[4:0], 3'b111});
   endtask

   task automatic measure();
      #200;
      for (int k = 0; k < 6; k++) ecnt[k] = 0;
      #(WIN);
   endtask

   function automatic int exp_edges(input logic [2:0] code, input logic s1, input logic [6:0] n1,
                                    input logic s2, input logic [6:0] n2);
      int p1 = s1 ? VCO_P : REF_P;
      int p2 = s2 ? VCO_P : REF_P;
      int d1 = (n1 < 2) ? 2 : int'(n1);
      int d2 = (n2 < 2) ? 2 : int'(n2);
      case (code)
         3'd0: return WIN / REF_P;
         3'd1: return WIN / (p1 * d1);
         3'd2: return WIN / (p1 * 2);
         3'd3: return WIN / (p1 * 3);
         3'd4: return WIN / (p2 * d2);
         3'd5: return WIN / (p2 * 2);
         3'd6: return WIN / (p2 * 4);
         default: return 0;
      endcase
   endfunction

   task automatic chk_freq(input string req, input int idx, input int expv);
      int act = ecnt[idx];
      total++;
      if ((expv == 0 && act != 0) || act < expv - 1 || act > expv + 1) begin
         failed++;
         $display("FAIL %s out%0d edges actual %0d expected %0d", req, idx + 1, act, expv);
      end
   endtask

   task automatic chk_oe(input string req, input logic [5:0] expv);
      @(negedge reg_clk);
      total++;
      if (clk_oe_o !== expv) begin
         failed++;
         $display("FAIL %s clk_oe_o actual %b expected %b", req, clk_oe_o, expv);
      end
   endtask

   task automatic chk_low(input string req, input logic [5:0] mask);
      @(negedge reg_clk);
      total++;
      if ((clk_o & mask) !== 6'b0) begin
         failed++;
         $display("FAIL %s clk_o actual %b expected %b", req, clk_o & mask, 6'b0);
      end
   endtask

   function automatic string req_of(input logic [2:0] code, input logic [6:0] n);
      if (code == 3'd7) return "R6";
      if ((code == 3'd1 || code == 3'd4) && n < 2) return "R4";
      if (code == 3'd1 || code == 3'd4) return "R3";
      if (code == 3'd0) return "R6";
      return "R5";
   endfunction

   initial begin
      #2000000;
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge reg_clk);
      rst_n = 1;
      // R1 reset state
      chk_oe("R1", 6'b000001);
      measure();
      chk_freq("R1", 0, WIN / REF_P);
      for (int k = 1; k < 6; k++) chk_freq("R1", k, 0);
      chk_low("R1", 6'b111110);

      // table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         logic [2:0] oi = VEC[v][21:19];
         logic [2:0] cd = VEC[v][18:16];
         logic       s1 = VEC[v][15];
         logic [6:0] n1 = VEC[v][14:8];
         logic       s2 = VEC[v][7];
         logic [6:0] n2 = VEC[v][6:0];
         wr(8'h0C, {s1, n1});
         wr(8'h47, {s2, n2});
         put_codes({6{cd}});
         wr(8'h09, 8'h6F);
         measure();
         chk_freq(req_of(cd, (cd == 3'd4) ? n2 : n1), int'(oi),
                  exp_edges(cd, s1, n1, s2, n2));
      end

      // R7 packing, fixed bits written as zero
      wr(8'h0C, {1'b0, 7'd5});
      wr(8'h47, {1'b1, 7'd8});
      wr(8'h44, {3'd0, 3'd2, 2'b01});
      wr(8'h45, {1'b1, 3'd5, 3'b000, 1'b1});
      wr(8'h46, {2'b10, 3'd4, 3'b000});
      measure();
      chk_freq("R7", 0, WIN / REF_P);
      chk_freq("R7", 1, WIN / (REF_P * 2));
      chk_freq("R7", 2, WIN / (REF_P * 3));
      chk_freq("R7", 3, WIN / (VCO_P * 2));
      chk_freq("R7", 4, WIN / (VCO_P * 4));
      chk_freq("R7", 5, WIN / (VCO_P * 8));

      // R11 stray writes leave everything alone
      wr(8'h10, 8'hFF);
      wr(8'h0D, 8'h81);
      wr(8'h43, 8'h00);
      chk_oe("R11", 6'b111111);
      measure();
      chk_freq("R11", 0, WIN / REF_P);
      chk_freq("R11", 5, WIN / (VCO_P * 8));

      // R8 enable bit mapping
      wr(8'h09, 8'h90); chk_oe("R8", 6'b000000);
      wr(8'h09, 8'h20); chk_oe("R8", 6'b010000);
      wr(8'h09, 8'h40); chk_oe("R8", 6'b100000);
      wr(8'h09, 8'h05); chk_oe("R8", 6'b000101);

      // R10 disabled outputs stay low
      measure();
      chk_freq("R10", 1, 0);
      chk_freq("R10", 3, 0);
      chk_low("R10", 6'b111010);
      chk_freq("R8", 0, WIN / REF_P);

      // R9 pin low kills all
      wr(8'h09, 8'h6F);
      oe_pin = 0;
      chk_oe("R9", 6'b000000);
      measure();
      for (int k = 0; k < 6; k++) chk_freq("R9", k, 0);
      oe_pin = 1;
      chk_oe("R9", 6'b111111);

      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule